// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Rising-Edge Pullup Boost

This block is one general-purpose I/O port of a small controller, modelled at the level of the three driver enables that each pin's output stage needs: a pull-down, a weak pullup and a short strong pullup. Software writes a per-pin output register. A pin whose register bit is 1 is held only by the weak pullup, so an outside device can still drag it low. The same pin therefore serves as an input as well as an output, with no direction register. Software reads back one of two paths, chosen per read. One path returns the register contents. The other returns the levels actually seen on the pins, after resynchronisation.

Each pin can be handed over on its own to a neighbouring peripheral. In that state the pin's level is the AND of its register bit and the peripheral's output. The register bit must therefore stay at 1 for the peripheral to control the pin. The peripherals sit on fixed bit positions. Bit 0 takes serial receive data and bit 1 drives serial transmit data. Bits 2 and 3 are interrupt request inputs, bits 4 and 5 are counter clock inputs, bit 6 is the external-memory write strobe and bit 7 is the read strobe. Input-type peripherals read the synchronised pin levels from a dedicated output.

Whenever a pin's effective level goes from low to high, the strong pullup is switched on for a fixed number of clock periods to speed up the rising edge.

Top module: `qbp_port`

## Requirements
- R1: While reset is asserted and at the first negedge after it, the output register holds all ones. pd_en reads 0x00, wpu_en 0xFF and spu_en 0x00, and rd_data with rd_sel=0 reads 0xFF.
- R2: When wr_en is 1, wr_data is stored in the output register at the next rising clock edge. With rd_sel=0, rd_data shows the stored value in the cycle that follows that edge.
- R3: For a pin not handed to a peripheral whose register bit is 0, pd_en is 1, wpu_en is 0 and spu_en is 0.
- R4: For a pin not handed to a peripheral whose register bit is 1, pd_en is 0 and wpu_en is 1. With rd_sel=1, an externally forced low pin reads 0 while the register path still reads 1.
- R5: With rd_sel=1, rd_data returns pin_in as it was two rising clock edges earlier.
- R6: When a pin's effective level rises from 0 to 1, spu_en for that pin is 1 for exactly BOOST_CYCLES clock periods (default 2), starting in the cycle of the rise, and then returns to 0.
- R7: spu_en for a pin drops at once when the pin's effective level falls. A new rise restarts the full boost interval.
- R8: A pin with alt_sel bit set has effective level equal to its register bit ANDed with its alt_out bit. Pins with alt_sel clear follow their register bit only, whatever their alt_out bit is.
- R9: A pin handed to a peripheral whose register bit is 0 keeps pd_en at 1 whatever its alt_out bit is.
- R10: alt_in carries the same synchronised pin levels that the pin read path returns, on every bit.
- R11: When wr_en is 0, the output register does not change, whatever is on wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the output register |
| wr_data | input | WIDTH | Value to store in the output register |
| rd_sel | input | 1 | Read path select: 0 = register, 1 = pin levels |
| rd_data | output | WIDTH | Read result of the selected path |
| alt_sel | input | WIDTH | Per-pin hand-over to a peripheral |
| alt_out | input | WIDTH | Peripheral output level per pin |
| alt_in | output | WIDTH | Synchronised pin levels for peripheral inputs |
| pin_in | input | WIDTH | Sensed pin levels |
| pd_en | output | WIDTH | Pull-down enable per pin |
| wpu_en | output | WIDTH | Weak pullup enable per pin |
| spu_en | output | WIDTH | Strong pullup (boost) enable per pin |

## Verification
The bench measures the boost width edge by edge. A design that counted from the clock edge after the rise, or that held the boost for three periods, would show spu_en in the wrong sample. The bench also cuts a boost short and restarts it. A design that kept boosting a pulled-down pin, or ignored a second rise, would be caught there. The bench forces a pin low while the register holds 1, which catches read paths that are swapped or missing the two-flop delay. Peripheral hand-over is exercised with mixed masks, which exposes an OR in place of an AND, or one pin's selection leaking into another.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

  // Effective drive level of one pin: the register bit, gated by the
  // peripheral output when the pin is handed over.
  function automatic logic drive_level(input logic reg_bit,
                                       input logic alt_mode,
                                       input logic alt_bit);
    return reg_bit & (alt_mode ? alt_bit : 1'b1);
  endfunction

  // Counter width able to hold boost_len-1.
  function automatic int unsigned boost_cnt_w(input int unsigned boost_len);
    return (boost_len <= 2) ? 1 : $clog2(boost_len);
  endfunction

endpackage

// File: rtl/qbp_out_reg.sv
module qbp_out_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '1;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qbp_pin_drv.sv
module qbp_pin_drv
  import qbp_pkg::*;
#(
  parameter int unsigned BOOST_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_bit,
  input  logic alt_mode,
  input  logic alt_bit,
  output logic pd_en,
  output logic wpu_en,
  output logic spu_en,
  output logic rise_evt
);
  localparam int unsigned CW = boost_cnt_w(BOOST_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(BOOST_CYCLES - 1);

  logic          level;
  logic          level_q;
  logic [CW-1:0] cnt;

  assign level    = drive_level(reg_bit, alt_mode, alt_bit);
  assign rise_evt = level & ~level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      cnt     <= '0;
    end else begin
      level_q <= level;
      if (!level)         cnt <= '0;
      else if (rise_evt)  cnt <= LOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign pd_en  = ~level;
  assign wpu_en = level;
  assign spu_en = level & (rise_evt | (cnt != '0));
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned BOOST_CYCLES = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_sel,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] alt_sel,
  input  logic [WIDTH-1:0] alt_out,
  output logic [WIDTH-1:0] alt_in,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] wpu_en,
  output logic [WIDTH-1:0] spu_en
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] rise_evt;

  qbp_out_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(latch_q)
  );

  qbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    qbp_pin_drv #(.BOOST_CYCLES(BOOST_CYCLES)) u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_bit  (latch_q[i]),
      .alt_mode (alt_sel[i]),
      .alt_bit  (alt_out[i]),
      .pd_en    (pd_en[i]),
      .wpu_en   (wpu_en[i]),
      .spu_en   (spu_en[i]),
      .rise_evt (rise_evt[i])
    );
  end

  assign rd_data = rd_sel ? pin_sync : latch_q;
  assign alt_in  = pin_sync;
endmodule

// File: rtl/qbp_port_chk.sv
module qbp_port_chk #(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned BOOST_CYCLES = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] alt_sel,
  input logic [WIDTH-1:0] alt_out,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] pin_sync,
  input logic [WIDTH-1:0] rise_evt,
  input logic [WIDTH-1:0] pd_en,
  input logic [WIDTH-1:0] wpu_en,
  input logic [WIDTH-1:0] spu_en
);
  localparam int unsigned RW = $clog2(BOOST_CYCLES + 2);

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         warm <= '0;
    else if (warm != 2) warm <= warm + 1'b1;
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> latch_q == $past(wr_data));

  a_r11_no_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(latch_q));

  a_r3_zero_pulls_down: assert property (@(posedge clk) disable iff (!rst_n)
    ((~latch_q) & ~pd_en) == '0);

  a_r4_one_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & ~alt_sel & ~wpu_en) == '0);

  a_r8_alt_low_pulls_down: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel & ~alt_out & ~pd_en) == '0);

  a_r6_boost_only_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spu_en & pd_en) == '0);

  a_r6_rise_starts_boost: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt & ~spu_en) == '0);

  if (SYNC_STAGES == 2) begin : g_sync_chk
    a_r5_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2) |-> pin_sync == $past(pin_in, 2));
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_run
    logic [RW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     run <= '0;
      else if (!spu_en[i])            run <= '0;
      else if (run <= BOOST_CYCLES)   run <= run + 1'b1;
    end
    a_r6_boost_length: assert property (@(posedge clk) disable iff (!rst_n)
      spu_en[i] |-> run < BOOST_CYCLES);
  end
endmodule

bind qbp_port qbp_port_chk #(
  .WIDTH(WIDTH), .BOOST_CYCLES(BOOST_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .alt_sel(alt_sel), .alt_out(alt_out), .pin_in(pin_in),
  .latch_q(latch_q), .pin_sync(pin_sync), .rise_evt(rise_evt),
  .pd_en(pd_en), .wpu_en(wpu_en), .spu_en(spu_en)
);

// File: tb/qbp_port_tb.sv
module qbp_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] alt_sel = 8'h00;
  logic [7:0] alt_out = 8'h00;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] rd_data, alt_in, pd_en, wpu_en, spu_en;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  qbp_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .alt_sel(alt_sel),
    .alt_out(alt_out), .alt_in(alt_in), .pin_in(pin_in),
    .pd_en(pd_en), .wpu_en(wpu_en), .spu_en(spu_en)
  );

  // {wr_data, alt_sel, alt_out, expected pd_en}
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'h00, 8'h00, 8'hFF},
    {8'hFF, 8'h00, 8'h00, 8'h00},
    {8'hA5, 8'h00, 8'h00, 8'h5A},
    {8'hFF, 8'h0F, 8'h05, 8'h0A},
    {8'h3C, 8'hC3, 8'hFF, 8'hC3},
    {8'hF0, 8'hFF, 8'h0F, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    wr_data = v; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pd_en", pd_en, 8'h00);
    chk("R1 wpu_en", wpu_en, 8'hFF);
    chk("R1 spu_en", spu_en, 8'h00);
    chk("R1 rd_data", rd_data, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pd_en, 8'h00);

    // R2 R3 R8 R9: vector table
    foreach (VEC[k]) begin
      alt_sel = VEC[k][23:16];
      alt_out = VEC[k][15:8];
      write_reg(VEC[k][31:24]);
      chk("R2 latch read", rd_data, VEC[k][31:24]);
      chk("R3/R8/R9 pd_en", pd_en, VEC[k][7:0]);
      chk("R3/R8 wpu_en", wpu_en, ~VEC[k][7:0]);
    end
    alt_sel = 8'h00; alt_out = 8'h00;

    // R11: no write without strobe
    write_reg(8'h96);
    wr_data = 8'h00;
    repeat (2) @(negedge clk);
    chk("R11 hold", rd_data, 8'h96);

    // R6: boost width
    write_reg(8'h00);
    @(negedge clk);
    chk("R3 no boost when low", spu_en, 8'h00);
    write_reg(8'h81);
    chk("R6 boost cycle 1", spu_en, 8'h81);
    @(negedge clk);
    chk("R6 boost cycle 2", spu_en, 8'h81);
    @(negedge clk);
    chk("R6 boost ended", spu_en, 8'h00);

    // R7: cut short, then restart
    write_reg(8'h00);
    write_reg(8'hFF);
    chk("R7 boost on", spu_en, 8'hFF);
    write_reg(8'h00);
    chk("R7 boost cut", spu_en, 8'h00);
    write_reg(8'hFF);
    chk("R7 restart 1", spu_en, 8'hFF);
    @(negedge clk);
    chk("R7 restart 2", spu_en, 8'hFF);
    @(negedge clk);
    chk("R7 restart end", spu_en, 8'h00);

    // R8 R6: peripheral output rise boosts pin 1 only
    alt_sel = 8'h02; alt_out = 8'h00;
    @(negedge clk);
    chk("R8 alt low", pd_en, 8'h02);
    alt_out = 8'h02;
    #1;
    chk("R6 alt rise boost", spu_en, 8'h02);
    @(negedge clk);
    chk("R6 alt boost 2", spu_en, 8'h02);
    @(negedge clk);
    chk("R6 alt boost end", spu_en, 8'h00);
    alt_sel = 8'h00; alt_out = 8'h00;

    // R4 R5 R10: pin path vs latch path
    pin_in = 8'h5A;
    rd_sel = 1'b1;
    @(negedge clk);
    chk("R5 one edge", rd_data, 8'hFF);
    @(negedge clk);
    chk("R5 two edges", rd_data, 8'h5A);
    chk("R10 alt_in", alt_in, 8'h5A);
    chk("R4 released", wpu_en, 8'hFF);
    pin_in = 8'h00;
    repeat (2) @(negedge clk);
    chk("R4 pin path low", rd_data, 8'h00);
    rd_sel = 1'b0;
    #1;
    chk("R4 latch path high", rd_data, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule